// File: doc/BRIEF.md
# Bit Test-and-Modify Read-Modify-Write Unit

This block carries out the two bit test-and-modify instructions of an 8-bit accumulator processor. It talks to a synchronous byte-wide memory port. A start pulse delivers the opcode, the address operand bytes and the accumulator value. The unit then reads the target byte and either clears or sets the bits selected by the accumulator. It writes the result back to the same address.

The unit reports the zero flag and pulses done on the final bus cycle. The zero flag is taken from the AND of the accumulator with the byte as it was before the change, not from the value written back. The unit keeps the instruction's cycle count: five cycles for the one-byte-address form and six for the two-byte-address form, counting the start cycle. It never alters the accumulator. Any opcode outside the four supported encodings is reported for one cycle and causes no memory access.

Top module: `bit_rmw_unit`

## Requirements
- R1: After reset the unit is idle. busy, mem_rd, mem_wr, done, illegal and zero_flag are all 0.
- R2: The legal opcodes are 0x14 (clear bits, page-zero address), 0x1C (clear bits, full address), 0x04 (set bits, page-zero address) and 0x0C (set bits, full address). When start arrives in idle with any other opcode, illegal is 1 in the next cycle only, with no mem_rd, mem_wr or done.
- R3: The page-zero forms address {8'h00, oper_lo}. The full forms address {oper_hi, oper_lo}. The write uses the same address as the read.
- R4: Take the start cycle as cycle 0. The page-zero forms read in cycle 2 and write in cycle 4. The full forms read in cycle 3 and write in cycle 5. busy is 1 from cycle 1 through the write cycle.
- R5: The clear-bits forms write back the read byte AND the inverted accumulator.
- R6: The set-bits forms write back the read byte OR the accumulator.
- R7: zero_flag becomes 1 when (read byte AND accumulator) is zero and 0 otherwise. It changes in the cycle after done and holds its value at all other times.
- R8: Opcode, operands and accumulator are captured in the start cycle. Later changes to these inputs are ignored, and so is any start pulse while busy.
- R9: When a clear-bits form finds (read byte AND accumulator) zero, the byte written back equals the byte read.
- R10: Each legal instruction makes exactly one read and exactly one write, two cycles apart. done is 1 only in the write cycle, and mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Instruction opcode |
| oper_lo | input | DATA_W | Low address operand byte |
| oper_hi | input | DATA_W | High address operand byte (full forms only) |
| acc_in | input | DATA_W | Accumulator value |
| busy | output | 1 | Instruction in progress |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_rd |
| zero_flag | output | 1 | Zero flag result |
| done | output | 1 | Pulses on the final (write) cycle |
| illegal | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
The checker assumes a memory that returns mem_rdata exactly one cycle after mem_rd. It also assumes that mem_rdata holds still in the modify cycle that the data checks look back on. The bench memory model is a single registered read path, so this timing is always met. The assertions also take the captured accumulator as the operand for the whole instruction. The stimulus tests this by scrambling acc_in, the operands and the opcode after every start, and by sending a second start while the unit is busy.

// File: rtl/bit_rmw_pkg.sv
package bit_rmw_pkg;
   localparam logic [7:0] OPC_CLR_ZP  = 8'h14;
   localparam logic [7:0] OPC_CLR_ABS = 8'h1C;
   localparam logic [7:0] OPC_SET_ZP  = 8'h04;
   localparam logic [7:0] OPC_SET_ABS = 8'h0C;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPLO,
      ST_OPHI,
      ST_READ,
      ST_MOD,
      ST_WRITE
   } rmw_state_t;
endpackage

// File: rtl/bit_rmw_decode.sv
module bit_rmw_decode
   import bit_rmw_pkg::*;
(
   input  logic [7:0] opcode,
   output logic       legal,
   output logic       is_set,
   output logic       is_abs
);
   always_comb begin
      legal  = 1'b1;
      is_set = 1'b0;
      is_abs = 1'b0;
      case (opcode)
         OPC_CLR_ZP:  begin is_set = 1'b0; is_abs = 1'b0; end
         OPC_CLR_ABS: begin is_set = 1'b0; is_abs = 1'b1; end
         OPC_SET_ZP:  begin is_set = 1'b1; is_abs = 1'b0; end
         OPC_SET_ABS: begin is_set = 1'b1; is_abs = 1'b1; end
         default:     legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/bit_rmw_alu.sv
module bit_rmw_alu #(
   parameter int W = 8
) (
   input  logic [W-1:0] mem_val,
   input  logic [W-1:0] acc_val,
   input  logic         set_mode,
   output logic [W-1:0] new_val,
   output logic         zero
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign new_val[i] = set_mode ? (mem_val[i] | acc_val[i])
                                   : (mem_val[i] & ~acc_val[i]);
   end
   // flag is a test of the original byte, not of the result
   assign zero = ~|(mem_val & acc_val);
endmodule

// File: rtl/bit_rmw_seq.sv
module bit_rmw_seq
   import bit_rmw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       abs_mode,
   output rmw_state_t state
);
   rmw_state_t nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (launch) nxt = ST_OPLO;
         ST_OPLO:  nxt = abs_mode ? ST_OPHI : ST_READ;
         ST_OPHI:  nxt = ST_READ;
         ST_READ:  nxt = ST_MOD;
         ST_MOD:   nxt = ST_WRITE;
         ST_WRITE: nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit
   import bit_rmw_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] oper_lo,
   input  logic [DATA_W-1:0] oper_hi,
   input  logic [DATA_W-1:0] acc_in,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              zero_flag,
   output logic              done,
   output logic              illegal
);
   localparam int PAGE_W = ADDR_W - DATA_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("bit_rmw_unit: DATA_W must be 8 for this opcode set");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("bit_rmw_unit: ADDR_W must be twice DATA_W");
   end

   rmw_state_t        state;
   logic              dec_legal, dec_set, dec_abs;
   logic              launch;
   logic              set_q, abs_q;
   logic [DATA_W-1:0] acc_q, lo_q, hi_q, rd_q;
   logic [DATA_W-1:0] alu_out;
   logic              alu_zero;

   bit_rmw_decode u_dec (
      .opcode (opcode),
      .legal  (dec_legal),
      .is_set (dec_set),
      .is_abs (dec_abs)
   );

   assign launch = start && (state == ST_IDLE) && dec_legal;

   bit_rmw_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .abs_mode (abs_q),
      .state    (state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_q <= 1'b0;
         abs_q <= 1'b0;
         acc_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (launch) begin
         set_q <= dec_set;
         abs_q <= dec_abs;
         acc_q <= acc_in;
         lo_q  <= oper_lo;
         hi_q  <= oper_hi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rd_q <= '0;
      else if (state == ST_MOD)  rd_q <= mem_rdata;
   end

   bit_rmw_alu #(.W(DATA_W)) u_alu (
      .mem_val  (rd_q),
      .acc_val  (acc_q),
      .set_mode (set_q),
      .new_val  (alu_out),
      .zero     (alu_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zero_flag <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         if (state == ST_WRITE) zero_flag <= alu_zero;
         illegal <= start && (state == ST_IDLE) && !dec_legal;
      end
   end

   assign mem_addr  = abs_q ? {hi_q, lo_q} : {{PAGE_W{1'b0}}, lo_q};
   assign mem_rd    = (state == ST_READ);
   assign mem_wr    = (state == ST_WRITE);
   assign mem_wdata = alu_out;
   assign done      = (state == ST_WRITE);
   assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/bit_rmw_unit_chk.sv
module bit_rmw_unit_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              done,
   input logic              illegal,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              zero_flag,
   input logic [DATA_W-1:0] acc_q,
   input logic              set_q
);
   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

   // R10
   wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd, 2));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_addr == $past(mem_addr, 2));

   // R2
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_rd && !mem_wr && !done));

   // R5
   clr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !set_q) |-> mem_wdata == ($past(mem_rdata) & ~acc_q));

   // R6
   set_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && set_q) |-> mem_wdata == ($past(mem_rdata) | acc_q));

   // R7
   z_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> zero_flag == (($past(mem_rdata, 2) & acc_q) == '0));

   // R7
   z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(zero_flag));

   // R9
   clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !set_q && (($past(mem_rdata) & acc_q) == '0))
         |-> mem_wdata == $past(mem_rdata));
endmodule

bind bit_rmw_unit bit_rmw_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .done      (done),
   .illegal   (illegal),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .zero_flag (zero_flag),
   .acc_q     (acc_q),
   .set_q     (set_q)
);

// File: tb/tb_bit_rmw_unit.sv
module tb_bit_rmw_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  oper_lo = 8'h00;
   logic [7:0]  oper_hi = 8'h00;
   logic [7:0]  acc_in = 8'h00;
   logic        busy, mem_rd, mem_wr, zero_flag, done, illegal;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic z_model = 1'b0;

   logic [7:0] dmem    [logic [15:0]];
   logic [7:0] ref_mem [logic [15:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   bit_rmw_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .oper_lo(oper_lo), .oper_hi(oper_hi), .acc_in(acc_in),
      .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .zero_flag(zero_flag),
      .done(done), .illegal(illegal)
   );

   function automatic logic [7:0] dut_mem(input logic [15:0] a);
      return dmem.exists(a) ? dmem[a] : 8'h00;
   endfunction

   function automatic logic [7:0] ref_rd(input logic [15:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= dut_mem(mem_addr);
      if (mem_wr) dmem[mem_addr] = mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic poke(input logic [15:0] a, input logic [7:0] v);
      dmem[a] = v;
      ref_mem[a] = v;
   endtask

   task automatic run_op(input logic [7:0] op, input logic [7:0] lo,
                         input logic [7:0] hi, input logic [7:0] acc);
      bit legal, setm, absm;
      int len;
      logic [15:0] a;
      logic [7:0] m, expw;
      logic expz;
      legal = 1'b1; setm = 1'b0; absm = 1'b0;
      case (op)
         8'h14: begin setm = 0; absm = 0; end
         8'h1C: begin setm = 0; absm = 1; end
         8'h04: begin setm = 1; absm = 0; end
         8'h0C: begin setm = 1; absm = 1; end
         default: legal = 1'b0;
      endcase
      @(negedge clk);
      start = 1'b1; opcode = op; oper_lo = lo; oper_hi = hi; acc_in = acc;
      @(negedge clk);
      start = 1'b0;
      // R8: scramble the inputs after capture
      acc_in = ~acc; oper_lo = lo ^ 8'h5A; oper_hi = hi ^ 8'hA5; opcode = 8'h0C;
      if (!legal) begin
         chk("R2 illegal pulse", illegal, 1'b1);
         chk("R2 no access", {mem_rd, mem_wr, done, busy}, 4'b0);
         @(negedge clk);
         chk("R2 illegal one cycle", {illegal, mem_rd, mem_wr, done, busy}, 5'b0);
         chk("R7 flag held after illegal", zero_flag, z_model);
         return;
      end
      len  = absm ? 6 : 5;
      a    = absm ? {hi, lo} : {8'h00, lo};
      m    = ref_rd(a);
      expw = setm ? (m | acc) : (m & ~acc);
      expz = ((m & acc) == 8'h00);
      for (int k = 1; k < len; k++) begin
         chk("R4 busy", busy, 1'b1);
         chk("R4 read cycle", mem_rd, (k == len - 3));
         chk("R10 write cycle", mem_wr, (k == len - 1));
         chk("R10 done cycle", done, (k == len - 1));
         chk("R2 no illegal", illegal, 1'b0);
         chk("R7 flag held", zero_flag, z_model);
         if (mem_rd || mem_wr) chk("R3 address", mem_addr, a);
         if (mem_wr) chk(setm ? "R6 write data" : "R5 write data", mem_wdata, expw);
         // R8: start while busy must be ignored
         start = (k == 2);
         if (k == 2) begin opcode = 8'h04; oper_lo = lo ^ 8'h01; end
         @(negedge clk);
      end
      start = 1'b0;
      ref_mem[a] = expw;
      z_model = expz;
      chk("R7 zero flag", zero_flag, expz);
      chk("R8 idle after one instruction", {busy, mem_rd, mem_wr, done}, 4'b0);
      chk(setm ? "R6 memory" : "R5 memory", dut_mem(a), expw);
      if (!setm && expz) chk("R9 unchanged byte", dut_mem(a), m);
      @(negedge clk);
      chk("R8 second start ignored", {busy, mem_rd, mem_wr}, 3'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", {busy, mem_rd, mem_wr, done, illegal, zero_flag}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {busy, mem_rd, mem_wr, done, illegal, zero_flag}, 6'b0);

      poke(16'h0010, 8'hA6);
      run_op(8'h14, 8'h10, 8'h77, 8'h33);
      chk("R5 example clear", dut_mem(16'h0010), 8'h84);
      chk("R7 example z0", zero_flag, 1'b0);
      poke(16'h0010, 8'hA6);
      run_op(8'h14, 8'h10, 8'h77, 8'h41);
      chk("R9 example clear keeps", dut_mem(16'h0010), 8'hA6);
      chk("R7 example z1", zero_flag, 1'b1);
      poke(16'h3456, 8'hA6);
      run_op(8'h0C, 8'h56, 8'h34, 8'h33);
      chk("R6 example set", dut_mem(16'h3456), 8'hB7);
      poke(16'h3456, 8'hA6);
      run_op(8'h0C, 8'h56, 8'h34, 8'h41);
      chk("R6 example set z1", dut_mem(16'h3456), 8'hE7);
      chk("R3 page zero untouched", dut_mem(16'h0056), 8'h00);
      poke(16'h00FF, 8'h0F);
      run_op(8'h04, 8'hFF, 8'hEE, 8'hF0);
      chk("R3 page-zero address ignores high byte", dut_mem(16'hEEFF), 8'h00);
      run_op(8'h1C, 8'hFF, 8'hEE, 8'hFF);

      run_op(8'h24, 8'h10, 8'h00, 8'hFF);
      run_op(8'h00, 8'h10, 8'h00, 8'hFF);
      run_op(8'h1D, 8'h10, 8'h00, 8'hFF);
      chk("R2 illegal left memory", dut_mem(16'h0010), 8'hA6);

      for (int i = 0; i < 30; i++) begin
         logic [7:0] ops [4];
         ops = '{8'h14, 8'h1C, 8'h04, 8'h0C};
         if (i % 3 == 0) poke({4'h1, 4'($urandom), 8'($urandom)}, 8'($urandom));
         run_op(ops[$urandom % 4], 8'($urandom), {4'h1, 4'($urandom)}, 8'($urandom));
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule